// File: doc/BRIEF.md
# Smart Card Half-Duplex Character Port

This block is the per-card character interface between host software and one smart card. The card has one bidirectional data line, and the block drives it through an open-drain style pull-down. The block also drives the card's reset line. It generates a card clock that a group of cards can share. The host fills a 256-byte buffer and starts a transmit. The block sends those bytes as asynchronous characters. When the last guard time ends, the block turns to listening and stores each character the card returns into the same buffer, starting again at address zero. The host reads the running byte count and the buffer contents.

Every register sits in the single system clock domain. The card clock and the bit timing come from enable pulses. The host decides when the card's reset is asserted and when it is released. The host also decides when a reply has ended and may raise the bit rate at any time by writing a new elementary time unit (ETU) length. The block does no answer-to-reset parsing and no rate negotiation.

Top module: `sc_port`

## Requirements
- R1: While reset is held, and in the first cycle after it: card_rst_n is 0, card_clk is 1, and io_drive_low, tx_busy, rx_active, rx_count and rx_parity_err are all 0.
- R2: card_clk has a period of 6 system clocks, high for 3 and low for 3. The first high phase starts when reset is released.
- R3: card_rst_n equals the inverse of card_rst_req as sampled at the previous clock edge.
- R4: When io_drive_low is 1, the line is pulled low. A character lasts 12 ETU: a low start bit, 8 data bits LSB first, then a parity bit that makes the total number of ones in the data and parity even, then 2 ETU with the line released. Every bit lasts exactly ETU×6 system clocks, and the start edges of consecutive characters are exactly 12 ETU apart.
- R5: After reset the ETU is 372 card clocks, so a bit lasts 2232 system clocks.
- R6: A pulse on etu_we with a nonzero etu_wdata sets the ETU to that number of card clocks. A write of zero leaves the ETU unchanged.
- R7: tx_go is accepted when tx_busy is 0 and tx_len is between 1 and 256. Once accepted, the block sends buffer bytes 0 to tx_len-1 in order, each exactly once, and holds tx_busy high until the last guard time ends. host_we has no effect while tx_busy is high.
- R8: In the cycle tx_busy falls, rx_active rises and rx_count is 0. Line activity while tx_busy is high, including the block's own echo, never changes rx_count. io_drive_low is never 1 while rx_active is 1.
- R9: While rx_active is 1, each received character is written to buffer address rx_count, and rx_count then increases by one. A receive write takes precedence over a host write in the same cycle. host_rdata shows the buffer byte at host_addr one cycle after host_addr is applied.
- R10: A received character whose parity bit breaks even parity sets rx_parity_err. The flag stays set until a tx_go or rx_go is accepted.
- R11: When tx_busy is 0, rx_go clears rx_count and rx_parity_err and enters receive. rx_go has no effect while tx_busy is 1.
- R12: A low pulse on the line that is shorter than half an ETU is not taken as a start bit.
- R13: rx_count stops at 256. Characters received after that point are discarded and never overwrite the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 8 | Host buffer address, used for both read and write |
| host_wdata | input | 8 | Host buffer write data |
| host_rdata | output | 8 | Buffer byte at host_addr, registered |
| etu_we | input | 1 | Load strobe for the ETU length |
| etu_wdata | input | 16 | ETU length in card clocks |
| tx_go | input | 1 | Start transmit of buffer bytes 0 to tx_len-1 |
| tx_len | input | 9 | Number of bytes to transmit (1 to 256) |
| rx_go | input | 1 | Restart receive at address zero |
| card_rst_req | input | 1 | Host request to hold the card in reset |
| io_in | input | 1 | Sensed level of the card data line |
| card_clk | output | 1 | Card clock, system clock divided by 6 |
| card_rst_n | output | 1 | Card reset, active low |
| io_drive_low | output | 1 | Pull-down enable for the open-drain data line |
| tx_busy | output | 1 | Transmit in progress |
| rx_active | output | 1 | Receive mode |
| rx_count | output | 9 | Number of characters stored since the last restart |
| rx_parity_err | output | 1 | Sticky parity error flag for the current receive |

## Verification
The transmitter is tried with a single byte at the reset-default rate, which measures the absolute bit length. At the fast rate it sends short commands of all-ones, all-zeros, alternating and single-bit bytes, which show whether bit order and parity are correct, and a 40-byte stepped sequence, where any skipped or repeated byte shows up as a wrong value. The receiver gets clean characters, a bad-parity character followed by a clean one to show that the flag is sticky, a short glitch that tells a false start from a real one, and a 257-character burst that tests the saturation and the discard. A host write during a transmit, and an rx_go during a transmit, show that inputs are ignored while busy.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int FRAME_BITS = 12;

  typedef enum logic [1:0] {PM_IDLE, PM_TX, PM_RX} port_mode_e;
  typedef enum logic [1:0] {RX_HUNT, RX_START, RX_DATA} rx_state_e;

  // One character as line levels, index 0 goes out first.
  function automatic logic [FRAME_BITS-1:0] char_frame(input logic [7:0] d);
    return {2'b11, ^d, d, 1'b0};
  endfunction

  // Parity mismatch of a received data byte and parity bit (even parity).
  function automatic logic parity_bad(input logic [7:0] d, input logic p);
    return (^d) ^ p;
  endfunction

endpackage

// File: rtl/sc_cclk_gen.sv
module sc_cclk_gen #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic card_clk,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HIGH = CW'(DIV / 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  assign cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
  assign tick    = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      card_clk <= 1'b1;
    end else begin
      cnt      <= cnt_nxt;
      card_clk <= (cnt_nxt < HIGH);
    end
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_clk_high_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_clk) |=> card_clk);

endmodule

// File: rtl/sc_byte_ram.sv
module sc_byte_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_b <= mem[raddr_b];
  end

  assign rdata_a = mem[raddr_a];

endmodule

// File: rtl/sc_tx_ser.sv
module sc_tx_ser import sc_pkg::*; #(
  parameter int ETU_W = 16,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             tick,
  input  logic [ETU_W-1:0] etu,
  input  logic [7:0]       cur_byte,
  output logic [LEN_W-2:0] rd_addr,
  output logic             busy,
  output logic             done,
  output logic             drive_low
);
  localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

  logic             run, hold;
  logic [3:0]       bit_ix;
  logic [ETU_W-1:0] tcnt;
  logic [LEN_W-1:0] ptr, last;
  logic [15:0]      frame;
  logic             bit_end, char_end;

  assign frame    = {{(16-FRAME_BITS){1'b1}}, char_frame(cur_byte)};
  assign bit_end  = run && !hold && tick && (tcnt == etu - 1'b1);
  assign char_end = bit_end && (bit_ix == LAST_BIT);
  assign done     = char_end && (ptr == last);
  assign busy     = run;
  assign rd_addr  = ptr[LEN_W-2:0];
  assign drive_low = run && !hold && !frame[bit_ix];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      hold   <= 1'b0;
      bit_ix <= '0;
      tcnt   <= '0;
      ptr    <= '0;
      last   <= '0;
    end else if (start) begin
      run    <= 1'b1;
      hold   <= 1'b1;
      bit_ix <= '0;
      tcnt   <= '0;
      ptr    <= '0;
      last   <= len - 1'b1;
    end else if (run && tick) begin
      if (hold) begin
        hold <= 1'b0;
      end else if (bit_end) begin
        tcnt <= '0;
        if (char_end) begin
          bit_ix <= '0;
          if (ptr == last) run <= 1'b0;
          else             ptr <= ptr + 1'b1;
        end else begin
          bit_ix <= bit_ix + 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + 1'b1) || $past(start)));
  assert_edge_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_low != $past(drive_low)) |-> $past(tick));

endmodule

// File: rtl/sc_rx_des.sv
module sc_rx_des import sc_pkg::*; #(
  parameter int ETU_W = 16,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic             tick,
  input  logic [ETU_W-1:0] etu,
  input  logic             line,
  output logic             wr_en,
  output logic [CNT_W-2:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic [CNT_W-1:0] count,
  output logic             perr
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1 << (CNT_W - 1));

  function automatic logic [ETU_W-1:0] mid_point(input logic [ETU_W-1:0] e);
    return (e < ETU_W'(2)) ? ETU_W'(1) : (e >> 1);
  endfunction

  rx_state_e        state;
  logic             s1, s2, s3;
  logic             fall;
  logic [ETU_W-1:0] rcnt;
  logic [3:0]       bix;
  logic [7:0]       sh;
  logic             start_pt, bit_pt, char_pt;

  assign fall     = s3 && !s2;
  assign start_pt = (state == RX_START) && tick && (rcnt == mid_point(etu) - 1'b1);
  assign bit_pt   = (state == RX_DATA) && tick && (rcnt == etu - 1'b1);
  assign char_pt  = bit_pt && (bix == 4'd8);
  assign wr_en    = enable && !clear && char_pt && (count != FULL);
  assign wr_addr  = count[CNT_W-2:0];
  assign wr_data  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= line; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_HUNT;
      rcnt  <= '0;
      bix   <= '0;
      sh    <= '0;
      count <= '0;
      perr  <= 1'b0;
    end else if (clear) begin
      state <= RX_HUNT;
      count <= '0;
      perr  <= 1'b0;
    end else if (!enable) begin
      state <= RX_HUNT;
    end else begin
      case (state)
        RX_HUNT: if (fall) begin
          state <= RX_START;
          rcnt  <= '0;
        end
        RX_START: if (tick) begin
          if (start_pt) begin
            rcnt  <= '0;
            bix   <= '0;
            state <= s2 ? RX_HUNT : RX_DATA;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (bit_pt) begin
            rcnt <= '0;
            if (!char_pt) begin
              sh  <= {s2, sh[7:1]};
              bix <= bix + 1'b1;
            end else begin
              perr  <= perr | parity_bad(sh, s2);
              if (count != FULL) count <= count + 1'b1;
              state <= RX_HUNT;
            end
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        default: state <= RX_HUNT;
      endcase
    end
  end

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == $past(count) + 1'b1) || (count == '0)));
  assert_count_cap_R13: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  assert_no_write_full_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < FULL));

endmodule

// File: rtl/sc_port.sv
module sc_port import sc_pkg::*; #(
  parameter int CLK_DIV   = 6,
  parameter int ETU_W     = 16,
  parameter int ETU_RESET = 372,
  parameter int BUF_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [BUF_AW-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              etu_we,
  input  logic [ETU_W-1:0]  etu_wdata,
  input  logic              tx_go,
  input  logic [BUF_AW:0]   tx_len,
  input  logic              rx_go,
  input  logic              card_rst_req,
  input  logic              io_in,
  output logic              card_clk,
  output logic              card_rst_n,
  output logic              io_drive_low,
  output logic              tx_busy,
  output logic              rx_active,
  output logic [BUF_AW:0]   rx_count,
  output logic              rx_parity_err
);
  localparam logic [BUF_AW:0] DEPTH = (BUF_AW+1)'(1 << BUF_AW);

  port_mode_e        mode;
  logic              tick;
  logic [ETU_W-1:0]  etu_q;
  logic              tx_accept, rx_accept, tx_done, rx_clear;
  logic [BUF_AW-1:0] tx_addr, rx_addr, ram_waddr;
  logic [7:0]        tx_byte, rx_data, ram_wdata;
  logic              rx_wr, ram_we;

  assign tx_accept = tx_go && !tx_busy && (tx_len != '0) && (tx_len <= DEPTH);
  assign rx_accept = rx_go && !tx_busy && !tx_accept;
  assign rx_clear  = tx_accept || rx_accept || tx_done;
  assign rx_active = (mode == PM_RX);

  assign ram_we    = rx_wr || (host_we && !tx_busy);
  assign ram_waddr = rx_wr ? rx_addr : host_addr;
  assign ram_wdata = rx_wr ? rx_data : host_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= PM_IDLE;
      etu_q      <= ETU_W'(ETU_RESET);
      card_rst_n <= 1'b0;
    end else begin
      card_rst_n <= !card_rst_req;
      if (etu_we && (etu_wdata != '0)) etu_q <= etu_wdata;
      if (tx_accept)      mode <= PM_TX;
      else if (tx_done)   mode <= PM_RX;
      else if (rx_accept) mode <= PM_RX;
    end
  end

  sc_cclk_gen #(.DIV(CLK_DIV)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .tick(tick));

  sc_byte_ram #(.AW(BUF_AW)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr_a(tx_addr), .rdata_a(tx_byte),
    .raddr_b(host_addr), .rdata_b(host_rdata));

  sc_tx_ser #(.ETU_W(ETU_W), .LEN_W(BUF_AW+1)) tx_i (
    .clk(clk), .rst_n(rst_n), .start(tx_accept), .len(tx_len), .tick(tick),
    .etu(etu_q), .cur_byte(tx_byte), .rd_addr(tx_addr), .busy(tx_busy),
    .done(tx_done), .drive_low(io_drive_low));

  sc_rx_des #(.ETU_W(ETU_W), .CNT_W(BUF_AW+1)) rx_i (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear), .enable(rx_active), .tick(tick),
    .etu(etu_q), .line(io_in), .wr_en(rx_wr), .wr_addr(rx_addr),
    .wr_data(rx_data), .count(rx_count), .perr(rx_parity_err));

  assert_half_duplex_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && rx_active));
  assert_quiet_in_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> !io_drive_low);
  assert_mode_tracks_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy == (mode == PM_TX));
  assert_rst_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (card_rst_n == !$past(card_rst_req)));

endmodule

// File: tb/sc_port_tb_top.sv
module sc_port_tb_top;
  localparam int ETU_FAST = 4;
  localparam int CYC_FAST = ETU_FAST * 6;
  localparam int WD_LIMIT = 195000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        etu_we = 1'b0;
  logic [15:0] etu_wdata = '0;
  logic        tx_go = 1'b0;
  logic [8:0]  tx_len = '0;
  logic        rx_go = 1'b0;
  logic        card_rst_req = 1'b0;
  logic        card_low = 1'b0;
  logic        line;
  logic        card_clk, card_rst_n, io_drive_low, tx_busy, rx_active, rx_parity_err;
  logic [8:0]  rx_count;

  assign line = !(io_drive_low || card_low);

  sc_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .etu_we(etu_we),
    .etu_wdata(etu_wdata), .tx_go(tx_go), .tx_len(tx_len), .rx_go(rx_go),
    .card_rst_req(card_rst_req), .io_in(line), .card_clk(card_clk),
    .card_rst_n(card_rst_n), .io_drive_low(io_drive_low), .tx_busy(tx_busy),
    .rx_active(rx_active), .rx_count(rx_count), .rx_parity_err(rx_parity_err));

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int ph = 0;
  logic exp_rst_n = 1'b0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-clock reference model of the card clock phase and the reset follower.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ph = 0;
      exp_rst_n = 1'b0;
    end else begin
      ph = (ph == 5) ? 0 : ph + 1;
      exp_rst_n = !card_rst_req;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(card_clk == (ph < 3), "R2 card clock phase", card_clk, ph < 3);
      chk(card_rst_n == exp_rst_n, "R3 card reset follows request", card_rst_n, exp_rst_n);
    end
    if (cyc > WD_LIMIT) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] d);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic etu_write(input logic [15:0] v);
    etu_we = 1'b1; etu_wdata = v;
    @(negedge clk);
    etu_we = 1'b0;
  endtask

  task automatic start_tx(input int n);
    tx_go = 1'b1; tx_len = 9'(n);
    @(negedge clk);
    tx_go = 1'b0;
  endtask

  task automatic pulse_rx_go();
    rx_go = 1'b1;
    @(negedge clk);
    rx_go = 1'b0;
  endtask

  task automatic wait_tx_idle();
    int w = 0;
    while (tx_busy && w < 40000) begin @(negedge clk); w++; end
  endtask

  // Card-side receiver: decodes characters from the line and compares them.
  task automatic mon_tx(input int n, input int etuc);
    int prev = -1;
    for (int c = 0; c < n; c++) begin
      logic [7:0] d;
      logic [7:0] e;
      logic p, g0, g1;
      int w;
      w = 0;
      while (io_drive_low !== 1'b1 && w < 40 * etuc) begin @(negedge clk); w++; end
      e = exp_q.pop_front();
      if (prev >= 0) chk(cyc - prev == 12 * etuc, "R4 start spacing", cyc - prev, 12 * etuc);
      prev = cyc;
      repeat (etuc / 2) @(negedge clk);
      chk(io_drive_low == 1'b1, "R4 start bit low", io_drive_low, 1);
      for (int b = 0; b < 8; b++) begin
        repeat (etuc) @(negedge clk);
        d[b] = !io_drive_low;
      end
      repeat (etuc) @(negedge clk); p  = !io_drive_low;
      repeat (etuc) @(negedge clk); g0 = !io_drive_low;
      repeat (etuc) @(negedge clk); g1 = !io_drive_low;
      chk(d == e, "R7 byte order and value", d, e);
      chk(p == ^d, "R4 even parity", p, ^d);
      chk(g0 && g1, "R4 guard released", {g0, g1}, 3);
    end
  endtask

  // Card-side transmitter, called at a falling clock edge.
  task automatic card_send(input logic [7:0] d, input bit bad, input int etuc);
    logic [11:0] f;
    f = {2'b11, (^d) ^ bad, d, 1'b0};
    for (int b = 0; b < 12; b++) begin
      card_low = !f[b];
      repeat (etuc) @(negedge clk);
    end
    card_low = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    logic [7:0] seq5 [5];
    int w;
    seq5[0] = 8'hFF; seq5[1] = 8'h00; seq5[2] = 8'hA5; seq5[3] = 8'h3C; seq5[4] = 8'h81;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: outputs still hold their reset values before the first edge
    chk(card_rst_n == 0, "R1 card_rst_n", card_rst_n, 0);
    chk(card_clk == 1, "R1 card_clk", card_clk, 1);
    chk(io_drive_low == 0, "R1 io_drive_low", io_drive_low, 0);
    chk(tx_busy == 0 && rx_active == 0, "R1 mode", {tx_busy, rx_active}, 0);
    chk(rx_count == 0 && rx_parity_err == 0, "R1 rx status", rx_count, 0);
    @(negedge clk);

    // R3: request asserted and released
    card_rst_req = 1'b1;
    @(negedge clk);
    chk(card_rst_n == 0, "R3 reset asserted", card_rst_n, 0);
    card_rst_req = 1'b0;
    chk(card_rst_n == 0, "R3 no change before edge", card_rst_n, 0);
    @(negedge clk);
    chk(card_rst_n == 1, "R3 reset released", card_rst_n, 1);

    // R5: default rate, start bit of 0x01 is a single low bit
    host_write(8'd0, 8'h01);
    start_tx(1);
    w = 0;
    while (io_drive_low !== 1'b1 && w < 100) begin @(negedge clk); w++; end
    w = 0;
    while (io_drive_low === 1'b1 && w < 5000) begin @(negedge clk); w++; end
    chk(w == 2232, "R5 default bit length", w, 2232);
    wait_tx_idle();
    chk(rx_active == 1 && rx_count == 0, "R8 receive entered with count 0", rx_count, 0);

    // R6: fast rate, zero write ignored
    etu_write(16'(ETU_FAST));
    etu_write(16'd0);
    for (int i = 0; i < 5; i++) begin host_write(8'(i), seq5[i]); exp_q.push_back(seq5[i]); end
    start_tx(5);
    mon_tx(5, CYC_FAST);
    wait_tx_idle();
    chk(rx_count == 0, "R8 own echo ignored", rx_count, 0);

    // R7: long command, stepped pattern
    for (int i = 0; i < 40; i++) begin
      host_write(8'(i), 8'(i * 7 + 3));
      exp_q.push_back(8'(i * 7 + 3));
    end
    start_tx(40);
    mon_tx(40, CYC_FAST);
    wait_tx_idle();

    // R7: host write during transmit has no effect
    host_write(8'd0, 8'h11);
    host_write(8'd1, 8'h22);
    exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    start_tx(2);
    fork
      mon_tx(2, CYC_FAST);
      begin repeat (50) @(negedge clk); host_write(8'd1, 8'hEE); end
    join
    wait_tx_idle();

    // R11: rx_go during transmit ignored
    host_write(8'd0, 8'h77);
    exp_q.push_back(8'h77);
    start_tx(1);
    pulse_rx_go();
    chk(tx_busy == 1 && rx_active == 0, "R11 rx_go ignored while busy", rx_active, 0);
    mon_tx(1, CYC_FAST);
    wait_tx_idle();
    chk(rx_active == 1 && rx_count == 0, "R8 switch to receive", rx_count, 0);

    // R9: clean reply
    repeat (10) @(negedge clk);
    card_send(8'h3B, 0, CYC_FAST);
    card_send(8'h9F, 0, CYC_FAST);
    card_send(8'h00, 0, CYC_FAST);
    card_send(8'h55, 0, CYC_FAST);
    repeat (CYC_FAST) @(negedge clk);
    chk(rx_count == 4, "R9 receive count", rx_count, 4);
    chk(rx_parity_err == 0, "R10 no parity error on clean bytes", rx_parity_err, 0);
    host_read(8'd0, rd); chk(rd == 8'h3B, "R9 buffer[0]", rd, 8'h3B);
    host_read(8'd1, rd); chk(rd == 8'h9F, "R9 buffer[1]", rd, 8'h9F);
    host_read(8'd2, rd); chk(rd == 8'h00, "R9 buffer[2]", rd, 8'h00);
    host_read(8'd3, rd); chk(rd == 8'h55, "R9 buffer[3]", rd, 8'h55);

    // R10: bad parity sets flag, stays set
    card_send(8'hA7, 1, CYC_FAST);
    repeat (CYC_FAST) @(negedge clk);
    chk(rx_parity_err == 1 && rx_count == 5, "R10 parity error flagged", rx_parity_err, 1);
    card_send(8'h12, 0, CYC_FAST);
    repeat (CYC_FAST) @(negedge clk);
    chk(rx_parity_err == 1, "R10 flag sticky", rx_parity_err, 1);

    // R11: restart receive
    pulse_rx_go();
    chk(rx_count == 0 && rx_parity_err == 0 && rx_active == 1, "R11 restart clears", rx_count, 0);

    // R12: glitch is not a start bit
    card_low = 1'b1;
    repeat (3) @(negedge clk);
    card_low = 1'b0;
    repeat (4 * CYC_FAST) @(negedge clk);
    chk(rx_count == 0, "R12 glitch ignored", rx_count, 0);
    card_send(8'h5C, 0, CYC_FAST);
    repeat (CYC_FAST) @(negedge clk);
    chk(rx_count == 1, "R12 real start still taken", rx_count, 1);
    host_read(8'd0, rd); chk(rd == 8'h5C, "R12 byte after glitch", rd, 8'h5C);

    // R13: saturation at 256
    pulse_rx_go();
    for (int i = 0; i < 256; i++) card_send(8'(i) ^ 8'h5A, 0, CYC_FAST);
    card_send(8'hC3, 0, CYC_FAST);
    repeat (CYC_FAST) @(negedge clk);
    chk(rx_count == 256, "R13 count saturates", rx_count, 256);
    host_read(8'd0, rd);   chk(rd == 8'h5A, "R13 first byte kept", rd, 8'h5A);
    host_read(8'd255, rd); chk(rd == 8'hA5, "R13 last stored byte", rd, 8'hA5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule